// File: doc/BRIEF.md
# Data Pointer Unit with Frame Pointer

This block keeps the address registers that a processor core uses for indirect data-memory accesses. It holds two free-standing 16-bit address registers and a frame pointer. The frame pointer pairs a 16-bit base with an 8-bit offset. For every access the core names one pointer, says whether the access is a read or a write, and asks for an increment, a decrement or no change. The unit returns the address for that access in the same cycle and updates the chosen pointer at the next clock edge.

Reads use the pointer as it stands and adjust it afterwards. Writes adjust the pointer first and use the adjusted value. On the frame pointer only the offset moves. The base stays where it is, so a routine can walk a local frame without losing its anchor. Every register also has a direct load port, and all four register values are visible at the outputs.

Top module: `addr_ptr_unit`

## Requirements
- R1: After reset, the base, the offset and both free-standing pointers all read zero.
- R2: On a read access (accValid=1, accWrite=0), effAddr is formed from the pointer value before adjustment. An increment or decrement becomes visible on the register output after the next rising edge.
- R3: On a write access (accWrite=1), effAddr is formed from the already adjusted value. After the edge the pointer holds that same value.
- R4: When the frame pointer is selected (accSel=2), effAddr is the base plus the zero-extended offset, truncated to 16 bits.
- R5: A frame-pointer adjustment changes only the offset and leaves the base untouched. The offset wraps within 8 bits: 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R6: Pointer 0 (accSel=0) and pointer 1 (accSel=1) wrap within 16 bits: 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF.
- R7: An access never changes a register that belongs to a pointer other than the selected one.
- R8: A direct load of a register wins over an automatic adjustment of that register in the same cycle. Loads of other registers happen at the same time. A load does not change effAddr in the cycle it is applied.
- R9: Nothing is adjusted when accValid=0, when accAdj=0 (none) or when accAdj=3 (reserved). accAdj=1 means increment and accAdj=2 means decrement. accSel=3 is reserved: it adjusts nothing and drives effAddr to zero.
- R10: effAddr is combinational from the access inputs and the current registers. It is valid in the cycle the access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | An access is presented this cycle |
| accSel | input | 2 | Pointer choice: 0 pointer 0, 1 pointer 1, 2 frame, 3 reserved |
| accWrite | input | 1 | 1 for a write access (pre-adjust), 0 for a read access (post-adjust) |
| accAdj | input | 2 | 0 none, 1 increment, 2 decrement, 3 none |
| ldDp0 | input | 1 | Load strobe for pointer 0 |
| ldDp0Val | input | 16 | Load value for pointer 0 |
| ldDp1 | input | 1 | Load strobe for pointer 1 |
| ldDp1Val | input | 16 | Load value for pointer 1 |
| ldBase | input | 1 | Load strobe for the frame base |
| ldBaseVal | input | 16 | Load value for the frame base |
| ldOffs | input | 1 | Load strobe for the frame offset |
| ldOffsVal | input | 8 | Load value for the frame offset |
| effAddr | output | 16 | Effective address of the current access |
| dp0Q | output | 16 | Pointer 0 register value |
| dp1Q | output | 16 | Pointer 1 register value |
| baseQ | output | 16 | Frame base register value |
| offsQ | output | 8 | Frame offset register value |

## Verification
A wrong register value shows up on its output one edge after the faulty update. It also shows up on effAddr in the very next access that selects that pointer. An off-by-one in the order of adjustment appears at once, in the same cycle, on effAddr for a write or for a read. A stray update of an unselected pointer or of the base shows up as a change on that register's output right after the edge. The directed cases line up each corner case so that its effect can be read at the ports without delay: the wraps, the mix of load and adjust in one cycle, and the reserved codes.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

  localparam int DP_COUNT = 2;

  typedef enum logic [1:0] {
    SEL_DP0  = 2'd0,
    SEL_DP1  = 2'd1,
    SEL_FP   = 2'd2,
    SEL_NONE = 2'd3
  } ptrSel_e;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_INC  = 2'd1,
    ADJ_DEC  = 2'd2,
    ADJ_RSVD = 2'd3
  } adjMode_e;

  typedef enum logic [1:0] {
    SRC_DP0  = 2'd0,
    SRC_DP1  = 2'd1,
    SRC_FP   = 2'd2,
    SRC_ZERO = 2'd3
  } addrSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [DP_COUNT-1:0] dpInc;
    logic [DP_COUNT-1:0] dpDec;
    logic                offsInc;
    logic                offsDec;
    logic                preAdj;   // address taken from the adjusted value
    addrSrc_e            addrSrc;
  } dpuStrobe_t;

endpackage

// File: rtl/dpu_ctrl.sv
module dpu_ctrl
  import dpu_pkg::*;
(
  input  logic       accValid,
  input  logic [1:0] accSel,
  input  logic       accWrite,
  input  logic [1:0] accAdj,
  output dpuStrobe_t strobe
);

  logic selValid;
  logic incReq;
  logic decReq;

  always_comb begin
    selValid = accValid && (accSel != SEL_NONE);
    incReq   = selValid && (accAdj == ADJ_INC);
    decReq   = selValid && (accAdj == ADJ_DEC);
  end

  for (genvar i = 0; i < DP_COUNT; i++) begin : g_dpStrobe
    always_comb begin
      strobe.dpInc[i] = incReq && (accSel == 2'(i));
      strobe.dpDec[i] = decReq && (accSel == 2'(i));
    end
  end

  always_comb begin
    strobe.offsInc = incReq && (accSel == SEL_FP);
    strobe.offsDec = decReq && (accSel == SEL_FP);
    strobe.preAdj  = accWrite;
    unique case (accSel)
      SEL_DP0: strobe.addrSrc = SRC_DP0;
      SEL_DP1: strobe.addrSrc = SRC_DP1;
      SEL_FP:  strobe.addrSrc = SRC_FP;
      default: strobe.addrSrc = SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/dpu_datapath.sv
module dpu_datapath
  import dpu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  dpuStrobe_t                       strobe,
  input  logic [DP_COUNT-1:0]              ldDp,
  input  logic [DP_COUNT-1:0][ADDR_W-1:0]  ldDpVal,
  input  logic                             ldBase,
  input  logic [ADDR_W-1:0]                ldBaseVal,
  input  logic                             ldOffs,
  input  logic [OFFS_W-1:0]                ldOffsVal,
  output logic [ADDR_W-1:0]                effAddr,
  output logic [DP_COUNT-1:0][ADDR_W-1:0]  dpQ,
  output logic [ADDR_W-1:0]                baseQ,
  output logic [OFFS_W-1:0]                offsQ
);

  localparam int PAD_W = ADDR_W - OFFS_W;
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [OFFS_W-1:0] ONE_O = OFFS_W'(1);

  logic [DP_COUNT-1:0][ADDR_W-1:0] dpAdj;
  logic [DP_COUNT-1:0][ADDR_W-1:0] dpAddr;
  logic [OFFS_W-1:0]               offsAdj;
  logic [OFFS_W-1:0]               offsUse;
  logic [ADDR_W-1:0]               fpAddr;

  for (genvar i = 0; i < DP_COUNT; i++) begin : g_dp
    always_comb begin
      if (strobe.dpInc[i])      dpAdj[i] = dpQ[i] + ONE_A;
      else if (strobe.dpDec[i]) dpAdj[i] = dpQ[i] - ONE_A;
      else                      dpAdj[i] = dpQ[i];
      dpAddr[i] = strobe.preAdj ? dpAdj[i] : dpQ[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  dpQ[i] <= '0;
      else if (ldDp[i])                            dpQ[i] <= ldDpVal[i];
      else if (strobe.dpInc[i] || strobe.dpDec[i]) dpQ[i] <= dpAdj[i];
    end
  end

  always_comb begin
    if (strobe.offsInc)      offsAdj = offsQ + ONE_O;
    else if (strobe.offsDec) offsAdj = offsQ - ONE_O;
    else                     offsAdj = offsQ;
    offsUse = strobe.preAdj ? offsAdj : offsQ;
    fpAddr  = baseQ + {{PAD_W{1'b0}}, offsUse};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  offsQ <= '0;
    else if (ldOffs)                             offsQ <= ldOffsVal;
    else if (strobe.offsInc || strobe.offsDec)   offsQ <= offsAdj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      baseQ <= '0;
    else if (ldBase) baseQ <= ldBaseVal;
  end

  always_comb begin
    unique case (strobe.addrSrc)
      SRC_DP0: effAddr = dpAddr[0];
      SRC_DP1: effAddr = dpAddr[1];
      SRC_FP:  effAddr = fpAddr;
      default: effAddr = '0;
    endcase
  end

endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit
  import dpu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic [1:0]        accSel,
  input  logic              accWrite,
  input  logic [1:0]        accAdj,
  input  logic              ldDp0,
  input  logic [ADDR_W-1:0] ldDp0Val,
  input  logic              ldDp1,
  input  logic [ADDR_W-1:0] ldDp1Val,
  input  logic              ldBase,
  input  logic [ADDR_W-1:0] ldBaseVal,
  input  logic              ldOffs,
  input  logic [OFFS_W-1:0] ldOffsVal,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] dp0Q,
  output logic [ADDR_W-1:0] dp1Q,
  output logic [ADDR_W-1:0] baseQ,
  output logic [OFFS_W-1:0] offsQ
);

  dpuStrobe_t                      strobe;
  logic [DP_COUNT-1:0][ADDR_W-1:0] dpQ;

  dpu_ctrl u_ctrl (
    .accValid (accValid),
    .accSel   (accSel),
    .accWrite (accWrite),
    .accAdj   (accAdj),
    .strobe   (strobe)
  );

  dpu_datapath #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .ldDp      ({ldDp1, ldDp0}),
    .ldDpVal   ({ldDp1Val, ldDp0Val}),
    .ldBase    (ldBase),
    .ldBaseVal (ldBaseVal),
    .ldOffs    (ldOffs),
    .ldOffsVal (ldOffsVal),
    .effAddr   (effAddr),
    .dpQ       (dpQ),
    .baseQ     (baseQ),
    .offsQ     (offsQ)
  );

  assign dp0Q = dpQ[0];
  assign dp1Q = dpQ[1];

endmodule

// File: rtl/dpu_checker.sv
module dpu_checker #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accValid,
  input logic [1:0]        accSel,
  input logic              accWrite,
  input logic [1:0]        accAdj,
  input logic              ldDp0,
  input logic              ldDp1,
  input logic              ldBase,
  input logic              ldOffs,
  input logic [OFFS_W-1:0] ldOffsVal,
  input logic [ADDR_W-1:0] effAddr,
  input logic [ADDR_W-1:0] dp0Q,
  input logic [ADDR_W-1:0] dp1Q,
  input logic [ADDR_W-1:0] baseQ,
  input logic [OFFS_W-1:0] offsQ
);

  logic [ADDR_W-1:0] fpSum;
  assign fpSum = baseQ + ADDR_W'(offsQ);

  a_r2_read_old_value: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && !accWrite && accSel == 2'd0) |-> (effAddr == dp0Q));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accWrite && accSel == 2'd0 && !ldDp0) |=> (dp0Q == $past(effAddr)));

  a_r4_frame_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && !accWrite && accSel == 2'd2) |-> (effAddr == fpSum));

  a_r5_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accSel == 2'd2 && !ldBase) |=> $stable(baseQ));

  a_r7_dp1_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (accSel != 2'd1 && !ldDp1) |=> $stable(dp1Q));

  a_r8_offs_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ldOffs |=> (offsQ == $past(ldOffsVal)));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((!accValid || accAdj == 2'd0 || accAdj == 2'd3) && !ldDp0) |=> $stable(dp0Q));

endmodule

bind addr_ptr_unit dpu_checker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (.*);

// File: tb/addr_ptr_unit_test.sv
module addr_ptr_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic [1:0]  accSel = 2'd0;
  logic        accWrite = 1'b0;
  logic [1:0]  accAdj = 2'd0;
  logic        ldDp0 = 1'b0, ldDp1 = 1'b0, ldBase = 1'b0, ldOffs = 1'b0;
  logic [15:0] ldDp0Val = '0, ldDp1Val = '0, ldBaseVal = '0;
  logic [7:0]  ldOffsVal = '0;
  logic [15:0] effAddr, dp0Q, dp1Q, baseQ;
  logic [7:0]  offsQ;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_ptr_unit uut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadReg(input int which, input logic [15:0] val);
    @(negedge clk);
    case (which)
      0: begin ldDp0 = 1'b1; ldDp0Val = val; end
      1: begin ldDp1 = 1'b1; ldDp1Val = val; end
      2: begin ldBase = 1'b1; ldBaseVal = val; end
      default: begin ldOffs = 1'b1; ldOffsVal = val[7:0]; end
    endcase
    @(posedge clk); #1;
    ldDp0 = 1'b0; ldDp1 = 1'b0; ldBase = 1'b0; ldOffs = 1'b0;
  endtask

  // Present one access, check effAddr in the same cycle, return after the edge
  task automatic access(input logic v, input logic [1:0] sel, input logic wr,
                        input logic [1:0] adj, input logic [15:0] expAddr,
                        input string tag);
    @(negedge clk);
    accValid = v; accSel = sel; accWrite = wr; accAdj = adj;
    #1 chk(tag, effAddr, expAddr);
    @(posedge clk); #1;
    accValid = 1'b0; accAdj = 2'd0; accWrite = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 dp0", dp0Q, 16'h0);
    chk("R1 dp1", dp1Q, 16'h0);
    chk("R1 base", baseQ, 16'h0);
    chk("R1 offs", {8'h0, offsQ}, 16'h0);
  endtask

  task automatic testDp0Order();
    loadReg(0, 16'h1234);
    access(1, 2'd0, 0, 2'd1, 16'h1234, "R2 R10 read inc addr");
    chk("R2 read inc reg", dp0Q, 16'h1235);
    access(1, 2'd0, 1, 2'd1, 16'h1236, "R3 write inc addr");
    chk("R3 write inc reg", dp0Q, 16'h1236);
    access(1, 2'd0, 1, 2'd2, 16'h1235, "R3 write dec addr");
    chk("R3 write dec reg", dp0Q, 16'h1235);
    access(1, 2'd0, 0, 2'd2, 16'h1235, "R2 read dec addr");
    chk("R2 read dec reg", dp0Q, 16'h1234);
  endtask

  task automatic testDp1Wrap();
    loadReg(1, 16'hFFFF);
    access(1, 2'd1, 0, 2'd1, 16'hFFFF, "R6 read inc addr");
    chk("R6 wrap up", dp1Q, 16'h0000);
    chk("R7 dp0 kept", dp0Q, 16'h1234);
    access(1, 2'd1, 1, 2'd2, 16'hFFFF, "R6 write dec addr");
    chk("R6 wrap down", dp1Q, 16'hFFFF);
  endtask

  task automatic testFrame();
    loadReg(2, 16'hFFF0);
    loadReg(3, 16'h0020);
    access(1, 2'd2, 0, 2'd1, 16'h0010, "R4 sum mod 2^16");
    chk("R5 offs inc", {8'h0, offsQ}, 16'h0021);
    chk("R5 base kept", baseQ, 16'hFFF0);
    chk("R7 dp1 kept", dp1Q, 16'hFFFF);
    chk("R7 dp0 kept", dp0Q, 16'h1234);
    loadReg(3, 16'h00FF);
    access(1, 2'd2, 1, 2'd1, 16'hFFF0, "R5 write inc wrap addr");
    chk("R5 offs wrap up", {8'h0, offsQ}, 16'h0000);
    access(1, 2'd2, 0, 2'd2, 16'hFFF0, "R5 read dec addr");
    chk("R5 offs wrap down", {8'h0, offsQ}, 16'h00FF);
    chk("R5 base kept 2", baseQ, 16'hFFF0);
    access(1, 2'd2, 1, 2'd0, 16'h00EF, "R4 write none addr");
    chk("R9 offs none", {8'h0, offsQ}, 16'h00FF);
  endtask

  task automatic testLoadPriority();
    @(negedge clk);
    accValid = 1'b1; accSel = 2'd0; accWrite = 1'b0; accAdj = 2'd1;
    ldDp0 = 1'b1; ldDp0Val = 16'h5555;
    ldOffs = 1'b1; ldOffsVal = 8'h42;
    #1 chk("R8 addr ignores load", effAddr, 16'h1234);
    @(posedge clk); #1;
    accValid = 1'b0; accAdj = 2'd0; ldDp0 = 1'b0; ldOffs = 1'b0;
    chk("R8 load wins", dp0Q, 16'h5555);
    chk("R8 other load", {8'h0, offsQ}, 16'h0042);
  endtask

  task automatic testNoAdjust();
    access(0, 2'd0, 0, 2'd1, 16'h5555, "R9 invalid addr");
    chk("R9 invalid no change", dp0Q, 16'h5555);
    access(1, 2'd0, 1, 2'd3, 16'h5555, "R9 reserved adj addr");
    chk("R9 reserved adj no change", dp0Q, 16'h5555);
    access(1, 2'd3, 0, 2'd1, 16'h0000, "R9 reserved sel addr");
    chk("R9 reserved sel dp0", dp0Q, 16'h5555);
    chk("R9 reserved sel dp1", dp1Q, 16'hFFFF);
    chk("R9 reserved sel offs", {8'h0, offsQ}, 16'h0042);
    chk("R9 reserved sel base", baseQ, 16'hFFF0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testDp0Order();
    testDp1Wrap();
    testFrame();
    testLoadPriority();
    testNoAdjust();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule